// File: doc/BRIEF.md
# AHB Slave-Port Arbitration Stage

This block sits at the slave side of a multi-master AHB-Lite interconnect and feeds one target slave. Each master input stage offers a held transfer request made of address and control. The block chooses one request to present as the slave's address phase. It then steers write data from whichever master owns the data phase that is in progress. The slave's ready and response go back to that owner, and every input stage learns in which cycle its request was taken.

Address-phase ownership and data-phase ownership live in separate state. A handover can therefore put a new master's address on the bus in the same cycle that the previous master finishes its last data phase. A wait state on that data phase freezes both of them together, so no transfer is dropped or duplicated.

Top module: `ahb_slave_port_arb`

## Requirements
- R1: When the slave is ready, at most one request is taken per cycle. Among valid requests, the lowest-numbered master wins (master 0 has the highest priority).
- R2: While the slave holds ready low, the presented address and control stay unchanged, even when a higher-priority request arrives.
- R3: `m_accept[i]` pulses only in a cycle where `s_readyout` is high and master i's request is presented. Every offered transfer is taken exactly once, in grant order.
- R4: After a NONSEQ (10) or SEQ (11) transfer from master i is taken, `s_wdata` carries master i's write data. It holds that value until the slave reports ready.
- R5: The data-phase owner sees `m_ready` equal to `s_readyout` and `m_resp` equal to `s_resp`. Every other master sees ready high and response OKAY (0).
- R6: With no valid request, HTRANS to the slave is IDLE (00).
- R7: A taken IDLE (00) or BUSY (01) transfer creates no data-phase owner. In the next data phase `s_wdata` is zero and all `m_ready` bits are high.
- R8: On an ERROR response (`s_resp` = 1), the owner keeps receiving the response through both cycles: the low-ready cycle and the following high-ready cycle.
- R9: Once a transfer with the lock bit set is taken, the next grant stays with the same master, and other masters wait.
- R10: A new master's address phase is taken in the same cycle that the previous master's waited data phase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req_vld | input | NM | Request pending from each input stage |
| m_req_addr | input | NM*AW | Request address per master |
| m_req_trans | input | NM*2 | Transfer type per master |
| m_req_write | input | NM | Write flag per master |
| m_req_size | input | NM*3 | Transfer size per master |
| m_req_burst | input | NM*3 | Burst type per master |
| m_req_lock | input | NM | Locked-sequence flag per master |
| m_wdata | input | NM*DW | Write data per master |
| m_accept | output | NM | Request taken this cycle |
| m_ready | output | NM | Data-phase ready per master |
| m_resp | output | NM | Data-phase response per master |
| s_addr | output | AW | Slave address |
| s_trans | output | 2 | Slave transfer type |
| s_write | output | 1 | Slave write flag |
| s_size | output | 3 | Slave transfer size |
| s_burst | output | 3 | Slave burst type |
| s_lock | output | 1 | Slave lock flag |
| s_wdata | output | DW | Slave write data |
| s_ready | output | 1 | Ready fed to the slave |
| s_readyout | input | 1 | Ready from the slave |
| s_resp | input | 1 | Response from the slave |

## Verification
Embedded properties check the following on every cycle:
- At most one request is taken per cycle.
- The granted index points at a valid request.
- Address and control stay stable during wait states.
- A lock keeps the grant on the same master.
- HTRANS is IDLE when nothing is requested.
- Ready and response are routed to the master whose transfer was taken.
- The owner is kept across the two ERROR cycles.

Only the bench's scenarios can show that the grant order follows priority with masters retiring, that no transfer is lost across a waited handover, and which write data lands in which cycle.

// File: rtl/ahbsp_pkg.sv
package ahbsp_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } htrans_e;

    typedef struct packed {
        htrans_e    trans;
        logic       write;
        logic [2:0] size;
        logic [2:0] burst;
        logic       lock;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    localparam ctl_t CTL_IDLE = '{trans: TR_IDLE, write: 1'b0, size: 3'd0,
                                  burst: 3'd0, lock: 1'b0};

    // True when the transfer type carries a data phase
    function automatic logic moves_data(htrans_e t);
        return (t == TR_NSEQ) || (t == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahbsp_arbiter.sv
module ahbsp_arbiter #(
    parameter int unsigned NM = 3,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hready,
    input  logic [NM-1:0] req_vld,
    input  logic [NM-1:0] req_lock,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);

    logic          pri_v;
    logic [IW-1:0] pri_i;
    logic          hold_q;
    logic [IW-1:0] hold_idx;
    logic          lock_q;
    logic [IW-1:0] lock_idx;

    // Fixed priority: lowest index wins
    always_comb begin
        pri_v = 1'b0;
        pri_i = '0;
        for (int i = NM - 1; i >= 0; i--) begin
            if (req_vld[i]) begin
                pri_v = 1'b1;
                pri_i = IW'(i);
            end
        end
    end

    always_comb begin
        if (hold_q) begin
            gnt_vld = 1'b1;
            gnt_idx = hold_idx;
        end else if (lock_q) begin
            gnt_vld = req_vld[lock_idx];
            gnt_idx = lock_idx;
        end else begin
            gnt_vld = pri_v;
            gnt_idx = pri_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            hold_idx <= '0;
            lock_q   <= 1'b0;
            lock_idx <= '0;
        end else begin
            hold_q   <= !hready && gnt_vld;
            hold_idx <= gnt_idx;
            if (hready) begin
                lock_q   <= gnt_vld && req_lock[gnt_idx];
                lock_idx <= gnt_idx;
            end
        end
    end

    // R1: a grant always points at a pending request
    p_gnt_valid_r1: assert property (@(posedge clk) disable iff (rst)
        gnt_vld |-> req_vld[gnt_idx]);

    // R2: a waited address phase keeps its owner
    p_gnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!hready && gnt_vld) |=> (gnt_vld && gnt_idx == $past(gnt_idx)));

    // R9: a taken locked transfer keeps the next grant on the same master
    p_lock_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (hready && gnt_vld && req_lock[gnt_idx]) |=> (!gnt_vld || gnt_idx == $past(gnt_idx)));

endmodule

// File: rtl/ahbsp_dphase.sv
module ahbsp_dphase
    import ahbsp_pkg::*;
#(
    parameter int unsigned NM = 3,
    parameter int unsigned IW = 2,
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hready,
    input  logic             hresp,
    input  logic             acc_vld,
    input  logic [IW-1:0]    acc_idx,
    input  htrans_e          acc_trans,
    input  logic [NM*DW-1:0] m_wdata,
    output logic [DW-1:0]    s_wdata,
    output logic [NM-1:0]    m_ready,
    output logic [NM-1:0]    m_resp
);

    logic          dp_v;
    logic [IW-1:0] dp_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_v   <= 1'b0;
            dp_idx <= '0;
        end else if (hready) begin
            dp_v   <= acc_vld && moves_data(acc_trans);
            dp_idx <= acc_idx;
        end
    end

    always_comb begin
        s_wdata = '0;
        for (int i = 0; i < NM; i++) begin
            if (dp_v && dp_idx == IW'(i)) s_wdata = m_wdata[i*DW +: DW];
        end
    end

    for (genvar g = 0; g < NM; g++) begin : g_route
        assign m_ready[g] = (dp_v && dp_idx == IW'(g)) ? hready : 1'b1;
        assign m_resp[g]  = (dp_v && dp_idx == IW'(g)) ? hresp  : 1'b0;
    end

    // R8: first ERROR cycle is followed by a cycle with the same owner
    p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (dp_v && hresp && !hready) |=> (dp_v && dp_idx == $past(dp_idx)));

endmodule

// File: rtl/ahb_slave_port_arb.sv
module ahb_slave_port_arb
    import ahbsp_pkg::*;
#(
    parameter int unsigned NM = 3,
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NM-1:0]    m_req_vld,
    input  logic [NM*AW-1:0] m_req_addr,
    input  logic [NM*2-1:0]  m_req_trans,
    input  logic [NM-1:0]    m_req_write,
    input  logic [NM*3-1:0]  m_req_size,
    input  logic [NM*3-1:0]  m_req_burst,
    input  logic [NM-1:0]    m_req_lock,
    input  logic [NM*DW-1:0] m_wdata,
    output logic [NM-1:0]    m_accept,
    output logic [NM-1:0]    m_ready,
    output logic [NM-1:0]    m_resp,
    output logic [AW-1:0]    s_addr,
    output logic [1:0]       s_trans,
    output logic             s_write,
    output logic [2:0]       s_size,
    output logic [2:0]       s_burst,
    output logic             s_lock,
    output logic [DW-1:0]    s_wdata,
    output logic             s_ready,
    input  logic             s_readyout,
    input  logic             s_resp
);

    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1;

    ctl_t          req_ctl [NM];
    ctl_t          sel_ctl;
    logic [AW-1:0] sel_addr;
    logic          gnt_vld;
    logic [IW-1:0] gnt_idx;

    for (genvar g = 0; g < NM; g++) begin : g_unpack
        assign req_ctl[g] = ctl_t'({m_req_trans[2*g +: 2], m_req_write[g],
                                    m_req_size[3*g +: 3], m_req_burst[3*g +: 3],
                                    m_req_lock[g]});
        assign m_accept[g] = gnt_vld && (gnt_idx == IW'(g)) && s_readyout;
    end

    ahbsp_arbiter #(.NM(NM), .IW(IW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .hready  (s_readyout),
        .req_vld (m_req_vld),
        .req_lock(m_req_lock),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        sel_ctl  = CTL_IDLE;
        sel_addr = '0;
        for (int i = 0; i < NM; i++) begin
            if (gnt_vld && gnt_idx == IW'(i)) begin
                sel_ctl  = req_ctl[i];
                sel_addr = m_req_addr[i*AW +: AW];
            end
        end
    end

    assign s_addr  = sel_addr;
    assign s_trans = sel_ctl.trans;
    assign s_write = sel_ctl.write;
    assign s_size  = sel_ctl.size;
    assign s_burst = sel_ctl.burst;
    assign s_lock  = sel_ctl.lock;
    assign s_ready = s_readyout;

    ahbsp_dphase #(.NM(NM), .IW(IW), .DW(DW)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .hready   (s_readyout),
        .hresp    (s_resp),
        .acc_vld  (gnt_vld),
        .acc_idx  (gnt_idx),
        .acc_trans(sel_ctl.trans),
        .m_wdata  (m_wdata),
        .s_wdata  (s_wdata),
        .m_ready  (m_ready),
        .m_resp   (m_resp)
    );

    // R1: never two acceptances in one cycle
    p_one_accept_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_accept));

    // R2: waited address and control stay put
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (s_trans != 2'b00 && !s_readyout) |=>
        (s_addr == $past(s_addr) && s_trans == $past(s_trans)));

    // R6: no request means an idle slave bus
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (m_req_vld == '0) |-> (s_trans == 2'b00));

    // R5: the master whose transfer was taken gets the slave's ready and response
    for (genvar g = 0; g < NM; g++) begin : g_chk
        p_route_r5: assert property (@(posedge clk) disable iff (rst)
            (m_accept[g] && s_trans[1]) |=>
            (m_ready[g] == s_readyout && m_resp[g] == s_resp));
    end

endmodule

// File: tb/sim_ahb_slave_port_arb.sv
`timescale 1ns/100ps
module sim_ahb_slave_port_arb;

    localparam int NM = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NM-1:0]    b_vld, b_lck;
    logic [31:0]      b_addr [NM];
    logic [1:0]       b_trn [NM];
    logic [NM*32-1:0] req_addr, wdata;
    logic [NM*2-1:0]  req_trans;
    logic [NM-1:0]    m_accept, m_ready, m_resp;
    logic [31:0]      s_addr, s_wdata;
    logic [1:0]       s_trans;
    logic             s_write, s_lock, s_ready;
    logic [2:0]       s_size, s_burst;
    logic             s_readyout, s_resp;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;
    logic [33:0] q[$];
    bit pend_v = 0;
    int pend_m = 0;

    function automatic logic [31:0] wd(input int i);
        return 32'hDA7A_0000 + i;
    endfunction

    always_comb begin
        for (int i = 0; i < NM; i++) begin
            req_addr[i*32 +: 32] = b_addr[i];
            req_trans[i*2 +: 2]  = b_trn[i];
            wdata[i*32 +: 32]    = wd(i);
        end
    end

    ahb_slave_port_arb u0 (
        .clk(clk), .rst(rst),
        .m_req_vld(b_vld), .m_req_addr(req_addr), .m_req_trans(req_trans),
        .m_req_write({NM{1'b1}}), .m_req_size({NM{3'd2}}), .m_req_burst({NM{3'd1}}),
        .m_req_lock(b_lck), .m_wdata(wdata),
        .m_accept(m_accept), .m_ready(m_ready), .m_resp(m_resp),
        .s_addr(s_addr), .s_trans(s_trans), .s_write(s_write), .s_size(s_size),
        .s_burst(s_burst), .s_lock(s_lock), .s_wdata(s_wdata), .s_ready(s_ready),
        .s_readyout(s_readyout), .s_resp(s_resp)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic req(input int i, input logic [31:0] a, input logic [1:0] t,
                       input logic lk);
        b_vld[i]  = 1'b1;
        b_addr[i] = a;
        b_trn[i]  = t;
        b_lck[i]  = lk;
    endtask

    task automatic expect_xfer(input int i, input logic [31:0] a);
        q.push_back({i[1:0], a});
    endtask

    task automatic obs();
        #0.5;
    endtask

    // Sample acceptances, cross the edge, retire taken requests
    task automatic tick();
        logic [NM-1:0] a;
        @(negedge clk);
        a = m_accept;
        @(posedge clk);
        #1;
        for (int i = 0; i < NM; i++) begin
            if (a[i]) begin
                b_vld[i] = 1'b0;
                b_trn[i] = 2'b00;
                b_lck[i] = 1'b0;
            end
        end
    endtask

    // Scoreboard monitor: write data for the pending owner, then the new acceptance
    always @(negedge clk) begin
        if (!rst) begin
            if (pend_v && s_readyout) begin
                check(s_wdata == wd(pend_m), "R4 write data of owner", s_wdata, wd(pend_m));
                pend_v = 0;
            end
            if (s_readyout && s_trans[1]) begin
                int idx;
                logic [33:0] e;
                idx = -1;
                for (int i = 0; i < NM; i++) if (m_accept[i]) idx = i;
                if (q.size() == 0) begin
                    check(1'b0, "R3 unexpected acceptance", s_addr, 32'h0);
                end else begin
                    e = q.pop_front();
                    check(idx == int'(e[33:32]) && s_addr == e[31:0],
                          "R1 grant order and address", {idx[15:0], s_addr[15:0]},
                          {14'd0, e[33:32], e[15:0]});
                end
                pend_v = 1;
                pend_m = idx;
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            nfail++;
            ntests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        b_vld = '0;
        b_lck = '0;
        for (int i = 0; i < NM; i++) begin
            b_addr[i] = '0;
            b_trn[i]  = 2'b00;
        end
        s_readyout = 1'b1;
        s_resp     = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state
        obs();
        check(s_trans == 2'b00, "R6 idle after reset", 32'(s_trans), 0);
        check(m_ready == 3'b111 && m_accept == 3'b000, "R5 reset ready/accept",
              {m_ready, m_accept}, 32'h38);
        check(s_wdata == 0, "R7 no owner after reset", s_wdata, 0);
        tick();

        // Single request
        req(1, 32'h100, 2'b10, 1'b0); expect_xfer(1, 32'h100);
        obs();
        check(m_accept == 3'b010, "R3 single accept", 32'(m_accept), 32'h2);
        tick();
        obs();
        check(s_trans == 2'b00, "R6 idle once drained", 32'(s_trans), 0);
        tick();

        // Three-way contention
        req(0, 32'h200, 2'b10, 1'b0); req(1, 32'h210, 2'b10, 1'b0); req(2, 32'h220, 2'b10, 1'b0);
        expect_xfer(0, 32'h200); expect_xfer(1, 32'h210); expect_xfer(2, 32'h220);
        obs();
        check(m_accept == 3'b001, "R1 master 0 wins", 32'(m_accept), 32'h1);
        tick(); tick(); tick();

        // Waited handover
        req(0, 32'h300, 2'b10, 1'b0); expect_xfer(0, 32'h300);
        tick();
        req(2, 32'h320, 2'b10, 1'b0); expect_xfer(2, 32'h320);
        s_readyout = 1'b0;
        obs();
        check(m_ready[0] == 1'b0, "R5 owner sees wait", 32'(m_ready), 32'h6);
        check(s_addr == 32'h320 && m_accept == 3'b000, "R3 no accept in wait", s_addr, 32'h320);
        tick();
        req(1, 32'h310, 2'b10, 1'b0);
        obs();
        check(s_addr == 32'h320 && m_accept == 3'b000, "R2 address held in wait", s_addr, 32'h320);
        tick();
        s_readyout = 1'b1; expect_xfer(1, 32'h310);
        obs();
        check(m_accept == 3'b100 && m_ready[0] == 1'b1, "R10 overlap accept",
              {m_accept, m_ready}, 32'h27);
        tick();
        obs();
        check(m_accept == 3'b010, "R1 deferred master taken", 32'(m_accept), 32'h2);
        tick();
        tick();

        // ERROR response
        req(1, 32'h400, 2'b10, 1'b0); expect_xfer(1, 32'h400);
        tick();
        s_readyout = 1'b0; s_resp = 1'b1;
        req(0, 32'h500, 2'b10, 1'b0); expect_xfer(0, 32'h500);
        obs();
        check(m_resp == 3'b010 && m_ready == 3'b101, "R8 first error cycle",
              {m_resp, m_ready}, 32'h15);
        tick();
        s_readyout = 1'b1;
        obs();
        check(m_resp == 3'b010 && m_ready == 3'b111, "R8 second error cycle",
              {m_resp, m_ready}, 32'h17);
        check(m_accept == 3'b001, "R10 accept on final error cycle", 32'(m_accept), 32'h1);
        tick();
        s_resp = 1'b0;
        obs();
        check(m_resp == 3'b000, "R5 okay after error", 32'(m_resp), 0);
        tick();

        // Locked sequence
        req(2, 32'h600, 2'b10, 1'b1); expect_xfer(2, 32'h600);
        tick();
        req(0, 32'h700, 2'b10, 1'b0); req(2, 32'h604, 2'b11, 1'b1); expect_xfer(2, 32'h604);
        obs();
        check(m_accept == 3'b100, "R9 lock holds grant", 32'(m_accept), 32'h4);
        tick();
        req(2, 32'h608, 2'b11, 1'b0); expect_xfer(2, 32'h608);
        obs();
        check(m_accept == 3'b100, "R9 last locked beat", 32'(m_accept), 32'h4);
        tick();
        expect_xfer(0, 32'h700);
        obs();
        check(m_accept == 3'b001, "R9 release to master 0", 32'(m_accept), 32'h1);
        tick();
        tick();

        // IDLE transfer taken, no data owner
        req(1, 32'h800, 2'b00, 1'b0);
        obs();
        check(m_accept == 3'b010 && s_trans == 2'b00, "R7 idle request taken",
              {m_accept, s_trans}, 32'h8);
        tick();
        obs();
        check(s_wdata == 0 && m_ready == 3'b111, "R7 no owner after idle", s_wdata, 0);
        tick();
        tick();

        check(q.size() == 0, "R3 no transfer lost", q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule